// File: doc/BRIEF.md
# RTC Bus Transaction Monitor

This block watches traffic on a two-wire serial bus that has already been decoded into discrete events. It follows the register-pointer accesses made to a battery-backed calendar clock slave and keeps a binary copy of the clock's time and date fields. The clock slave stores its fields as packed BCD. A master first writes a register pointer. It then either writes further bytes or issues a repeated start and reads bytes back. In both cases the pointer advances by one for every data byte.

Each event arrives as a one-cycle `ev_valid` beat. The beat carries a 3-bit kind, a payload byte and the acknowledge bit that belongs to that byte. The monitor matches the address against the clock's 7-bit slave address. It decodes each data byte into the field selected by the current pointer, according to the hour-mode bit. When the burst ends with a stop, the monitor raises a one-cycle `done` strobe and marks the burst as a read or a write. A monitoring or logging block downstream can take a consistent time-stamp at that strobe.

Top module: `rtcmon`

## Requirements
- R1: Event kinds use these codes: 0 start, 1 repeated start, 2 stop, 3 address-write, 4 address-read, 5 data-write, 6 data-read. For address events, payload bits 6:0 carry the 7-bit address and bit 7 is ignored. After a start, an acknowledged address-write to 0x68 arms the monitor, and the next acknowledged data-write byte becomes the register pointer.
- R2: After the pointer is set, each acknowledged data-write byte is decoded into the field at the pointer, and the pointer then increases by one. An 8-bit pointer wraps from 255 to 0.
- R3: A stop during a write burst makes `done` high for exactly the one cycle after the stop event, with `done_rd` low.
- R4: A repeated start after the pointer write, followed by an acknowledged address-read to 0x68, starts read mode. Each data-read byte is decoded at the pointer with auto-increment, whatever the master's acknowledge bit is. A stop then makes `done` high for one cycle with `done_rd` high.
- R5: Register 0 gives `sec` as the BCD value of bits 6:0 and `halt` as bit 7. Register 1 gives `min` as the BCD value of bits 6:0, and its bit 7 is ignored.
- R6: In register 2, bit 6 high selects 12-hour mode: `pm` is bit 5 and `hour` is the BCD value of bits 4:0. Bit 6 low gives `hour` as the BCD value of bits 5:0 with `pm` low. `mode12` follows bit 6.
- R7: Register 3 gives `wday` from bits 2:0. Register 4 gives `mday` as the BCD value of bits 5:0. Register 5 gives `month` as the BCD value of bits 4:0. Register 6 gives `year` as 2000 plus the BCD value of the whole byte. A BCD value is the low nibble plus ten times the high nibble.
- R8: An address event whose address is not 0x68 returns the monitor to idle. Later data bytes then change no field, and a later stop gives no `done`.
- R9: A NACK on an address event or on a data-write byte aborts the burst. The NACKed byte changes no field, and the following stop gives no `done`.
- R10: A data byte at pointer 7 or above leaves every field unchanged, but the pointer still advances.
- R11: Between data bytes the fields hold their values, and `done` stays low except for its one-cycle pulse.
- R12: A synchronous active-high reset clears every field to zero (`year` reads 2000), clears the pointer to 0 and holds `done` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | One-cycle bus event beat |
| ev_kind | input | 3 | Event code (R1) |
| ev_byte | input | 8 | Address or data payload |
| ev_ack | input | 1 | Acknowledge bit of the payload, 1 = ACK |
| done | output | 1 | One-cycle end-of-burst strobe |
| done_rd | output | 1 | Burst was a read (valid with done) |
| halt | output | 1 | Oscillator-halt flag from register 0 |
| sec | output | 7 | Seconds, binary |
| min | output | 7 | Minutes, binary |
| mode12 | output | 1 | 12-hour mode selected |
| pm | output | 1 | Afternoon flag in 12-hour mode |
| hour | output | 6 | Hours, binary |
| wday | output | 3 | Day of week |
| mday | output | 6 | Day of month, binary |
| month | output | 5 | Month, binary |
| year | output | 12 | Year, 2000 plus the stored value |

## Verification
The case hardest to reach from the ports is a pointer that wraps from 255 back to 0 inside one burst. A byte aimed at an unused register must be dropped while the next byte lands in the seconds field. The bench reaches it by writing 0xFF as the pointer and following it with two data bytes. It also starts a burst at register 5 and runs it past the last time register into the control and scratch bytes. Almost every field encoding is covered by full write and read bursts over a hundred time values, with 12-hour and 24-hour modes alternating. Address mismatches and NACKs are mixed in, each followed by bytes that would otherwise change a field.

// File: rtl/rtcmon_pkg.sv
package rtcmon_pkg;

    typedef enum logic [2:0] {
        EV_START   = 3'd0,
        EV_RSTART  = 3'd1,
        EV_STOP    = 3'd2,
        EV_ADDR_WR = 3'd3,
        EV_ADDR_RD = 3'd4,
        EV_DATA_WR = 3'd5,
        EV_DATA_RD = 3'd6,
        EV_NONE    = 3'd7
    } bus_ev_e;

    typedef enum logic [2:0] {
        MS_IDLE,
        MS_ADDR,
        MS_PTR,
        MS_WRITE,
        MS_RADDR,
        MS_READ
    } mon_state_e;

    // register indices whose meaning the decoder depends on
    localparam int REG_SEC       = 0;
    localparam int REG_MIN       = 1;
    localparam int REG_HOUR      = 2;
    localparam int REG_WDAY      = 3;
    localparam int REG_MDAY      = 4;
    localparam int REG_MONTH     = 5;
    localparam int REG_YEAR      = 6;
    localparam int NUM_TIME_REGS = 7;

    typedef struct packed {
        logic       halt;
        logic [6:0] sec;
        logic [6:0] min;
        logic       mode12;
        logic       pm;
        logic [5:0] hour;
        logic [2:0] wday;
        logic [5:0] mday;
        logic [4:0] month;
        logic [7:0] year_ofs;
    } rtc_fields_t;

    // packed two-digit BCD to binary: low + 10 * high
    function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
        logic [7:0] hi;
        hi = {4'd0, v[7:4]};
        return {4'd0, v[3:0]} + (hi << 3) + (hi << 1);
    endfunction

endpackage

// File: rtl/rtcmon_seq.sv
module rtcmon_seq
    import rtcmon_pkg::*;
#(
    parameter int                ADDR_W     = 7,
    parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'h68,
    parameter int                PTR_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_valid_i,
    input  logic [2:0]       ev_kind_i,
    input  logic [7:0]       ev_byte_i,
    input  logic             ev_ack_i,
    output logic             apply_o,
    output logic [PTR_W-1:0] apply_ptr_o,
    output logic             done_o,
    output logic             done_rd_o
);

    localparam logic [PTR_W-1:0] PTR_STEP = PTR_W'(1);

    typedef struct packed {
        mon_state_e       st;
        logic [PTR_W-1:0] ptr;
        logic             done;
        logic             rd;
    } seq_t;

    seq_t    seq_d, seq_q;
    bus_ev_e kind;
    logic    addr_hit;
    logic    apply_d;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        apply_d    = 1'b0;
        kind       = bus_ev_e'(ev_kind_i);
        addr_hit   = ev_ack_i && (ev_byte_i[ADDR_W-1:0] == SLAVE_ADDR);

        if (ev_valid_i) begin
            if (kind == EV_START) begin
                seq_d.st = MS_ADDR;
            end else begin
                case (seq_q.st)
                    MS_ADDR: begin
                        if (kind == EV_ADDR_WR)
                            seq_d.st = addr_hit ? MS_PTR : MS_IDLE;
                        else if (kind == EV_ADDR_RD || kind == EV_STOP)
                            seq_d.st = MS_IDLE;
                    end
                    MS_PTR: begin
                        if (kind == EV_DATA_WR) begin
                            if (ev_ack_i) begin
                                seq_d.ptr = PTR_W'(ev_byte_i);
                                seq_d.st  = MS_WRITE;
                            end else begin
                                seq_d.st = MS_IDLE;
                            end
                        end else if (kind == EV_STOP) begin
                            seq_d.st = MS_IDLE;
                        end
                    end
                    MS_WRITE: begin
                        if (kind == EV_RSTART) begin
                            seq_d.st = MS_RADDR;
                        end else if (kind == EV_DATA_WR) begin
                            if (ev_ack_i) begin
                                apply_d   = 1'b1;
                                seq_d.ptr = seq_q.ptr + PTR_STEP;
                            end else begin
                                seq_d.st = MS_IDLE;
                            end
                        end else if (kind == EV_STOP) begin
                            seq_d.done = 1'b1;
                            seq_d.rd   = 1'b0;
                            seq_d.st   = MS_IDLE;
                        end
                    end
                    MS_RADDR: begin
                        if (kind == EV_ADDR_RD)
                            seq_d.st = addr_hit ? MS_READ : MS_IDLE;
                        else if (kind == EV_ADDR_WR || kind == EV_STOP)
                            seq_d.st = MS_IDLE;
                    end
                    MS_READ: begin
                        if (kind == EV_DATA_RD) begin
                            apply_d   = 1'b1;
                            seq_d.ptr = seq_q.ptr + PTR_STEP;
                        end else if (kind == EV_RSTART) begin
                            seq_d.st = MS_RADDR;
                        end else if (kind == EV_STOP) begin
                            seq_d.done = 1'b1;
                            seq_d.rd   = 1'b1;
                            seq_d.st   = MS_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '{st: MS_IDLE, ptr: '0, done: 1'b0, rd: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign apply_o     = apply_d;
    assign apply_ptr_o = seq_q.ptr;
    assign done_o      = seq_q.done;
    assign done_rd_o   = seq_q.rd;

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        seq_q.done |=> !seq_q.done);

    // R3
    done_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_q.done) |-> $past(ev_valid_i && ev_kind_i == EV_STOP));

    // R2
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        apply_o |=> seq_q.ptr == $past(seq_q.ptr) + PTR_STEP);

    // R9
    nack_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_valid_i && ev_kind_i == EV_DATA_WR && !ev_ack_i && seq_q.st == MS_WRITE)
        |=> seq_q.st == MS_IDLE);

    // R12
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (seq_q.st == MS_IDLE && seq_q.ptr == '0 && !seq_q.done));

endmodule

// File: rtl/rtcmon_fields.sv
module rtcmon_fields
    import rtcmon_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             apply_i,
    input  logic [PTR_W-1:0] ptr_i,
    input  logic [7:0]       data_i,
    output rtc_fields_t      fields_o
);

    localparam logic [PTR_W-1:0] FIRST_SPARE = PTR_W'(NUM_TIME_REGS);

    rtc_fields_t fld_d, fld_q;
    logic [7:0]  bin_sec, bin_min, bin_h12, bin_h24, bin_mday, bin_month, bin_year;

    always_comb begin
        bin_sec   = bcd_to_bin({1'b0, data_i[6:0]});
        bin_min   = bcd_to_bin({1'b0, data_i[6:0]});
        bin_h12   = bcd_to_bin({3'b0, data_i[4:0]});
        bin_h24   = bcd_to_bin({2'b0, data_i[5:0]});
        bin_mday  = bcd_to_bin({2'b0, data_i[5:0]});
        bin_month = bcd_to_bin({3'b0, data_i[4:0]});
        bin_year  = bcd_to_bin(data_i);

        fld_d = fld_q;
        if (apply_i) begin
            case (ptr_i)
                PTR_W'(REG_SEC): begin
                    fld_d.halt = data_i[7];
                    fld_d.sec  = bin_sec[6:0];
                end
                PTR_W'(REG_MIN): begin
                    fld_d.min = bin_min[6:0];
                end
                PTR_W'(REG_HOUR): begin
                    fld_d.mode12 = data_i[6];
                    if (data_i[6]) begin
                        fld_d.pm   = data_i[5];
                        fld_d.hour = bin_h12[5:0];
                    end else begin
                        fld_d.pm   = 1'b0;
                        fld_d.hour = bin_h24[5:0];
                    end
                end
                PTR_W'(REG_WDAY): begin
                    fld_d.wday = data_i[2:0];
                end
                PTR_W'(REG_MDAY): begin
                    fld_d.mday = bin_mday[5:0];
                end
                PTR_W'(REG_MONTH): begin
                    fld_d.month = bin_month[4:0];
                end
                PTR_W'(REG_YEAR): begin
                    fld_d.year_ofs = bin_year;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fld_q <= '0;
        end else begin
            fld_q <= fld_d;
        end
    end

    assign fields_o = fld_q;

    // R10
    spare_reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (apply_i && ptr_i >= FIRST_SPARE) |=> $stable(fld_q));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !apply_i |=> $stable(fld_q));

    // R6
    h24_no_pm_chk: assert property (@(posedge clk) disable iff (rst)
        (apply_i && ptr_i == PTR_W'(REG_HOUR) && !data_i[6]) |=> (!fld_q.pm && !fld_q.mode12));

    // R12
    fields_reset_chk: assert property (@(posedge clk)
        rst |=> fld_q == '0);

endmodule

// File: rtl/rtcmon.sv
module rtcmon
    import rtcmon_pkg::*;
#(
    parameter int         ADDR_W     = 7,
    parameter logic [6:0] SLAVE_ADDR = 7'h68,
    parameter int         PTR_W      = 8,
    parameter int         YEAR_W     = 12,
    parameter int         YEAR_BASE  = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [2:0]        ev_kind,
    input  logic [7:0]        ev_byte,
    input  logic              ev_ack,
    output logic              done,
    output logic              done_rd,
    output logic              halt,
    output logic [6:0]        sec,
    output logic [6:0]        min,
    output logic              mode12,
    output logic              pm,
    output logic [5:0]        hour,
    output logic [2:0]        wday,
    output logic [5:0]        mday,
    output logic [4:0]        month,
    output logic [YEAR_W-1:0] year
);

    localparam logic [YEAR_W-1:0] YEAR_ORIGIN = YEAR_W'(YEAR_BASE);

    logic             apply;
    logic [PTR_W-1:0] apply_ptr;
    rtc_fields_t      fields;

    rtcmon_seq #(
        .ADDR_W    (ADDR_W),
        .SLAVE_ADDR(SLAVE_ADDR[ADDR_W-1:0]),
        .PTR_W     (PTR_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ev_valid_i (ev_valid),
        .ev_kind_i  (ev_kind),
        .ev_byte_i  (ev_byte),
        .ev_ack_i   (ev_ack),
        .apply_o    (apply),
        .apply_ptr_o(apply_ptr),
        .done_o     (done),
        .done_rd_o  (done_rd)
    );

    rtcmon_fields #(
        .PTR_W(PTR_W)
    ) u_fields (
        .clk     (clk),
        .rst     (rst),
        .apply_i (apply),
        .ptr_i   (apply_ptr),
        .data_i  (ev_byte),
        .fields_o(fields)
    );

    assign halt   = fields.halt;
    assign sec    = fields.sec;
    assign min    = fields.min;
    assign mode12 = fields.mode12;
    assign pm     = fields.pm;
    assign hour   = fields.hour;
    assign wday   = fields.wday;
    assign mday   = fields.mday;
    assign month  = fields.month;
    assign year   = YEAR_ORIGIN + YEAR_W'(fields.year_ofs);

    // R8
    foreign_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_kind == EV_ADDR_WR && ev_byte[6:0] != SLAVE_ADDR)
        |=> !apply);

endmodule

// File: tb/sim_rtcmon.sv
module sim_rtcmon;

    localparam int K_START = 0, K_RSTART = 1, K_STOP = 2, K_AWR = 3,
                   K_ARD = 4, K_DWR = 5, K_DRD = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic        ev_valid;
    logic [2:0]  ev_kind;
    logic [7:0]  ev_byte;
    logic        ev_ack;
    logic        done, done_rd, halt, mode12, pm;
    logic [6:0]  sec, min;
    logic [5:0]  hour, mday;
    logic [2:0]  wday;
    logic [4:0]  month;
    logic [11:0] year;

    int n_chk = 0;
    int n_fail = 0;
    int mptr = 0;
    int e_sec, e_min, e_hour, e_pm, e_m12, e_halt, e_wday, e_mday, e_month, e_year;

    always #10 clk = ~clk;

    rtcmon u0 (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_byte(ev_byte), .ev_ack(ev_ack), .done(done), .done_rd(done_rd),
        .halt(halt), .sec(sec), .min(min), .mode12(mode12), .pm(pm),
        .hour(hour), .wday(wday), .mday(mday), .month(month), .year(year)
    );

    function automatic logic [7:0] to_bcd(input int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        e_sec = 0; e_min = 0; e_hour = 0; e_pm = 0; e_m12 = 0; e_halt = 0;
        e_wday = 0; e_mday = 0; e_month = 0; e_year = 2000; mptr = 0;
    endtask

    // expected field update from the register layout of R5, R6, R7, R10
    task automatic model_apply(input int p, input logic [7:0] b);
        case (p)
            0: begin e_halt = int'(b[7]); e_sec = int'(b[3:0]) + 10 * int'(b[6:4]); end
            1: e_min = int'(b[3:0]) + 10 * int'(b[6:4]);
            2: begin
                e_m12 = int'(b[6]);
                if (b[6]) begin
                    e_pm = int'(b[5]); e_hour = int'(b[3:0]) + 10 * int'(b[4]);
                end else begin
                    e_pm = 0; e_hour = int'(b[3:0]) + 10 * int'(b[5:4]);
                end
            end
            3: e_wday = int'(b[2:0]);
            4: e_mday = int'(b[3:0]) + 10 * int'(b[5:4]);
            5: e_month = int'(b[3:0]) + 10 * int'(b[4]);
            6: e_year = 2000 + int'(b[3:0]) + 10 * int'(b[7:4]);
            default: ;
        endcase
    endtask

    task automatic check_all(input string ctx);
        chk({"R5 sec ", ctx}, int'(sec), e_sec);
        chk({"R5 halt ", ctx}, int'(halt), e_halt);
        chk({"R5 min ", ctx}, int'(min), e_min);
        chk({"R6 hour ", ctx}, int'(hour), e_hour);
        chk({"R6 pm ", ctx}, int'(pm), e_pm);
        chk({"R6 mode12 ", ctx}, int'(mode12), e_m12);
        chk({"R7 wday ", ctx}, int'(wday), e_wday);
        chk({"R7 mday ", ctx}, int'(mday), e_mday);
        chk({"R7 month ", ctx}, int'(month), e_month);
        chk({"R7 year ", ctx}, int'(year), e_year);
    endtask

    task automatic send(input int k, input logic [7:0] b, input logic a);
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = 3'(k); ev_byte = b; ev_ack = a;
        @(negedge clk);
        ev_valid = 1'b0; ev_kind = 3'd7; ev_byte = 8'h00; ev_ack = 1'b1;
    endtask

    task automatic open_wr(input int p);
        send(K_START, 8'h00, 1'b1);
        send(K_AWR, 8'h68, 1'b1);
        send(K_DWR, 8'(p), 1'b1);
        mptr = p;
    endtask

    task automatic wb(input logic [7:0] b);
        send(K_DWR, b, 1'b1);
        model_apply(mptr, b);
        mptr = (mptr + 1) % 256;
    endtask

    task automatic open_rd(input int p);
        open_wr(p);
        send(K_RSTART, 8'h00, 1'b1);
        send(K_ARD, 8'h68, 1'b1);
    endtask

    task automatic rb(input logic [7:0] b, input logic a);
        send(K_DRD, b, a);
        model_apply(mptr, b);
        mptr = (mptr + 1) % 256;
    endtask

    task automatic close_exp(input int rd, input string tag);
        send(K_STOP, 8'h00, 1'b1);
        chk({tag, " done pulse"}, int'(done), 1);
        chk({tag, " done_rd"}, int'(done_rd), rd);
        @(negedge clk);
        chk({"R11 done one cycle ", tag}, int'(done), 0);
    endtask

    task automatic close_none(input string tag);
        send(K_STOP, 8'h00, 1'b1);
        chk({tag, " no done"}, int'(done), 0);
        @(negedge clk);
        chk({tag, " no done later"}, int'(done), 0);
    endtask

    task automatic time_bytes(input int i, output logic [7:0] v [7]);
        int h;
        v[0] = to_bcd(i % 60) | ((i % 3 == 0) ? 8'h80 : 8'h00);
        v[1] = to_bcd((i * 7) % 60) | ((i % 4 == 1) ? 8'h80 : 8'h00);
        if (i % 2 == 1) begin
            h = i % 12 + 1;
            v[2] = 8'h40 | (((i / 2) % 2 == 1) ? 8'h20 : 8'h00) | to_bcd(h);
        end else begin
            v[2] = to_bcd(i % 24);
        end
        v[3] = 8'(i % 7 + 1);
        v[4] = to_bcd(i % 31 + 1);
        v[5] = to_bcd(i % 12 + 1);
        v[6] = to_bcd(i % 100);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v [7];
        rst = 1'b1; ev_valid = 1'b0; ev_kind = 3'd7; ev_byte = 8'h00; ev_ack = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        // R12 reset state
        check_all("R12 reset");
        chk("R12 done at reset", int'(done), 0);

        // R1 pointer selects the first target register
        open_wr(4);
        wb(to_bcd(27));
        chk("R1 pointer targets mday", int'(mday), 27);
        close_exp(0, "R3");

        // R2 R3 R5 R6 R7: full write bursts over many time values
        for (int i = 0; i < 100; i++) begin
            time_bytes(i, v);
            open_wr(0);
            for (int r = 0; r < 7; r++) wb(v[r]);
            close_exp(0, "R3 write sweep");
            check_all("R2 write sweep");
        end

        // R4 read bursts, last byte NACKed by master
        for (int i = 0; i < 50; i++) begin
            time_bytes(i + 37, v);
            open_rd(0);
            for (int r = 0; r < 7; r++) rb(v[r], (r == 6) ? 1'b0 : 1'b1);
            close_exp(1, "R4 read sweep");
            check_all("R4 read sweep");
        end

        // R8 wrong address on the write side
        send(K_START, 8'h00, 1'b1);
        send(K_AWR, 8'h50, 1'b1);
        send(K_DWR, 8'h00, 1'b1);
        send(K_DWR, 8'h45, 1'b1);
        check_all("R8 foreign write");
        close_none("R8 foreign write");
        // R8 wrong address on the read side
        open_wr(0);
        send(K_RSTART, 8'h00, 1'b1);
        send(K_ARD, 8'h51, 1'b1);
        send(K_DRD, 8'h33, 1'b1);
        check_all("R8 foreign read");
        close_none("R8 foreign read");

        // R9 NACKed address
        send(K_START, 8'h00, 1'b1);
        send(K_AWR, 8'h68, 1'b0);
        send(K_DWR, 8'h00, 1'b1);
        send(K_DWR, 8'h12, 1'b1);
        check_all("R9 nack addr");
        close_none("R9 nack addr");
        // R9 NACKed data byte
        open_wr(0);
        send(K_DWR, 8'h12, 1'b0);
        send(K_DWR, 8'h34, 1'b1);
        check_all("R9 nack data");
        close_none("R9 nack data");

        // R10 burst running past the time registers
        open_wr(5);
        wb(8'h09);
        wb(8'h42);
        wb(8'h93);
        wb(8'h77);
        chk("R10 month kept", int'(month), 9);
        chk("R10 year kept", int'(year), 2042);
        close_exp(0, "R10");
        check_all("R10 spare regs");
        // R10 R2 pointer wrap from 255 to 0
        open_wr(255);
        send(K_DWR, 8'h59, 1'b1);
        check_all("R10 ptr 255 ignored");
        mptr = 0;
        wb(8'h31);
        chk("R2 wrap into seconds", int'(sec), 31);
        close_exp(0, "R2 wrap");
        // R10 control register alone
        open_wr(7);
        wb(8'h10);
        close_exp(0, "R10 control");
        check_all("R10 control");

        // R11 hold across idle cycles and a partial header
        repeat (5) @(negedge clk);
        check_all("R11 idle");
        chk("R11 done idle", int'(done), 0);
        send(K_START, 8'h00, 1'b1);
        send(K_AWR, 8'h68, 1'b1);
        check_all("R11 header only");
        chk("R11 no done header", int'(done), 0);

        // R12 reset in the middle of a burst
        open_wr(2);
        wb(8'h65);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_all("R12 mid reset");
        chk("R12 done after reset", int'(done), 0);
        // after reset the monitor is idle: data without a header is dropped
        send(K_DWR, 8'h22, 1'b1);
        check_all("R12 idle after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule